// File: doc/BRIEF.md
# Vectored interrupt priority controller

This block sits between the interrupt and reset request lines of a small processor subsystem and the core's vector fetch. Each clock it looks at every request, decides which one the core must serve, and presents that source's service-routine address on a registered 16-bit output with a valid flag. Reset requests always win, and the reset kind selects one of three vectors. The kind arrives already decoded from outside. A non-maskable request comes next. The maskable sources follow, in fixed index order.

Software running in the privileged special mode can promote any one maskable source above all the other maskable ones. It does this by writing the low byte of that source's vector into a promotion register. The real-time-interrupt source then drops into the rank that the promoted source left. Writes made outside special mode have no effect. A byte that matches no source leaves the default order in place.

While the system is in a low-power state with this block's clock stopped, a purely combinational wake output rises as soon as the non-maskable request or an enabled, unmasked maskable request appears.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_req` is high the selected vector depends only on `rst_kind`: 0 gives 0xFFFE, 1 gives 0xFFFC, 2 gives 0xFFFA and 3 gives 0xFFFE. This holds whatever the other request inputs are.
- R2: When no reset is requested, `nmi_req` selects vector 0xFFF8 ahead of every maskable source, and `imask` has no effect on it.
- R3: Maskable source i has vector 0xFFF6 - 2*i. With no promotion active, the pending source with the lowest index wins.
- R4: While `imask` is 1, every maskable request is ignored. With no reset and no NMI, `vec_valid` is then 0.
- R5: A maskable request whose `irq_en` bit is 0 is not a candidate, even if it is the lowest index raised.
- R6: A write of byte B with `special_mode` high makes the source whose vector's low byte equals B win over every other maskable source, starting from the cycle after the write.
- R7: While a source P other than the real-time source (index `RTI_IDX`) is promoted, the real-time source ranks exactly where P would rank by index, and loses its own default rank.
- R8: A write with `special_mode` low leaves the promotion state unchanged.
- R9: A promotion byte that matches no source's vector low byte restores the default index order.
- R10: `vec_addr` and `vec_valid` change one clock edge after the inputs change. When nothing is selected, the outputs are `vec_valid`=0 and `vec_addr`=0x0000.
- R11: `wake` is combinational. It equals `lp_mode` AND (`nmi_req` OR any source with `irq_req`, `irq_en` high and `imask` low).
- R12: A synchronous `rst` clears both outputs to 0 and removes any promotion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | Reset exception request |
| rst_kind | input | 2 | Decoded reset kind: 0 power-on, 1 clock-monitor, 2 watchdog |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | NUM_SRC | Maskable request lines |
| irq_en | input | NUM_SRC | Per-source enables |
| imask | input | 1 | Global mask for maskable requests |
| cfg_we | input | 1 | Promotion register write strobe |
| cfg_wdata | input | 8 | Promotion byte |
| special_mode | input | 1 | Allows register writes when high |
| lp_mode | input | 1 | Low-power state, clock stopped |
| wake | output | 1 | Asynchronous wake-up |
| vec_addr | output | 16 | Selected service vector |
| vec_valid | output | 1 | A request is selected |

## Verification
The bench builds the block with eight maskable sources, the real-time source at index 0 and base 0xFFFE. Because of that choice, source 0 is normally the strongest maskable source. Promoting source 5 therefore moves source 0 into rank 5, so source 3 visibly beats it while source 0 still beats source 6. Eight sources also leave the promotion byte 0x55 unmatched, which exercises the no-promotion fallback.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef enum logic [1:0] {
        RK_POWER  = 2'd0,
        RK_CLKMON = 2'd1,
        RK_WDOG   = 2'd2,
        RK_SPARE  = 2'd3
    } rst_kind_e;

    localparam int SLOT_POWER  = 0;
    localparam int SLOT_CLKMON = 1;
    localparam int SLOT_WDOG   = 2;
    localparam int SLOT_NMI    = 3;
    localparam int SLOT_MSK0   = 4;

    typedef struct packed {
        logic        valid;
        logic [15:0] addr;
    } vec_sel_t;

    function automatic logic [15:0] vec_of_slot(input logic [15:0] base, input int slot);
        return base - 16'(2 * slot);
    endfunction

    function automatic logic [15:0] reset_vec(input logic [15:0] base, input rst_kind_e kind);
        case (kind)
            RK_CLKMON: return vec_of_slot(base, SLOT_CLKMON);
            RK_WDOG:   return vec_of_slot(base, SLOT_WDOG);
            default:   return vec_of_slot(base, SLOT_POWER);
        endcase
    endfunction

endpackage

// File: rtl/irqv_promo_reg.sv
module irqv_promo_reg
    import irqv_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       special,
    input  logic [7:0]                 wdata,
    output logic                       promo_hit,
    output logic [$clog2(NUM_SRC)-1:0] promo_idx
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [7:0] promo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            promo_q <= 8'h00;
        end else if (wr_en && special) begin
            promo_q <= wdata;
        end
    end

    always_comb begin
        logic [15:0] v;
        promo_hit = 1'b0;
        promo_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            v = vec_of_slot(VEC_BASE, SLOT_MSK0 + i);
            if (!promo_hit && (v[7:0] == promo_q)) begin
                promo_hit = 1'b1;
                promo_idx = IDX_W'(i);
            end
        end
    end

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !special) |=> $stable(promo_q)); // R8
    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && special) |=> (promo_q == $past(wdata))); // R6

endmodule

// File: rtl/irqv_mask_arb.sv
module irqv_mask_arb #(
    parameter int NUM_SRC = 8,
    parameter int RTI_IDX = 0
) (
    input  logic [NUM_SRC-1:0]         req_valid,
    input  logic                       promo_hit,
    input  logic [$clog2(NUM_SRC)-1:0] promo_idx,
    output logic                       win,
    output logic [$clog2(NUM_SRC)-1:0] win_idx
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic                 moved;
    logic [NUM_SRC-1:0]   slot_live;
    logic [IDX_W-1:0]     slot_src [NUM_SRC];
    logic                 top_hit;
    logic                 found;
    logic [IDX_W-1:0]     pick;

    assign moved   = promo_hit && (promo_idx != IDX_W'(RTI_IDX));
    assign top_hit = promo_hit && req_valid[promo_idx];

    for (genvar j = 0; j < NUM_SRC; j++) begin : g_slot
        assign slot_src[j] = (moved && (promo_idx == IDX_W'(j))) ? IDX_W'(RTI_IDX) : IDX_W'(j);
        if (j == RTI_IDX) begin : g_rti
            assign slot_live[j] = !moved && req_valid[slot_src[j]];
        end else begin : g_plain
            assign slot_live[j] = req_valid[slot_src[j]];
        end
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int j = 0; j < NUM_SRC; j++) begin
            if (!found && slot_live[j]) begin
                found = 1'b1;
                pick  = slot_src[j];
            end
        end
        win     = top_hit || found;
        win_idx = top_hit ? promo_idx : pick;
    end

    always_comb begin
        AST_WINNER_PENDING: assert (!win || req_valid[win_idx]); // R5
    end

endmodule

// File: rtl/irqv_wake.sv
module irqv_wake #(
    parameter int NUM_SRC = 8
) (
    input  logic               lp_mode,
    input  logic               nmi_req,
    input  logic [NUM_SRC-1:0] req_valid,
    output logic               wake
);
    assign wake = lp_mode && (nmi_req || (|req_valid));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter int          RTI_IDX  = 0,
    parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_req,
    input  logic [1:0]         rst_kind,
    input  logic               nmi_req,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               imask,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_wdata,
    input  logic               special_mode,
    input  logic               lp_mode,
    output logic               wake,
    output logic [15:0]        vec_addr,
    output logic               vec_valid
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] req_valid;
    logic               promo_hit;
    logic [IDX_W-1:0]   promo_idx;
    logic               arb_win;
    logic [IDX_W-1:0]   arb_idx;
    vec_sel_t           sel_d;
    vec_sel_t           sel_q;

    assign req_valid = irq_req & irq_en & {NUM_SRC{~imask}};

    irqv_promo_reg #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_promo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .special   (special_mode),
        .wdata     (cfg_wdata),
        .promo_hit (promo_hit),
        .promo_idx (promo_idx)
    );

    irqv_mask_arb #(.NUM_SRC(NUM_SRC), .RTI_IDX(RTI_IDX)) u_arb (
        .req_valid (req_valid),
        .promo_hit (promo_hit),
        .promo_idx (promo_idx),
        .win       (arb_win),
        .win_idx   (arb_idx)
    );

    irqv_wake #(.NUM_SRC(NUM_SRC)) u_wake (
        .lp_mode   (lp_mode),
        .nmi_req   (nmi_req),
        .req_valid (req_valid),
        .wake      (wake)
    );

    always_comb begin
        sel_d = '0;
        if (rst_req) begin
            sel_d.valid = 1'b1;
            sel_d.addr  = reset_vec(VEC_BASE, rst_kind_e'(rst_kind));
        end else if (nmi_req) begin
            sel_d.valid = 1'b1;
            sel_d.addr  = vec_of_slot(VEC_BASE, SLOT_NMI);
        end else if (arb_win) begin
            sel_d.valid = 1'b1;
            sel_d.addr  = vec_of_slot(VEC_BASE, SLOT_MSK0 + int'(arb_idx));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign vec_addr  = sel_q.addr;
    assign vec_valid = sel_q.valid;

    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (vec_valid && (vec_addr >= VEC_BASE - 16'd4))); // R1
    AST_NMI_OVER_MASK: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && nmi_req) |=> (vec_valid && vec_addr == VEC_BASE - 16'd6)); // R2
    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (rst)
        (imask && !rst_req && !nmi_req) |=> !vec_valid); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec_addr == 16'h0000)); // R10
    AST_WAKE_NMI: assert property (@(posedge clk) disable iff (rst)
        (lp_mode && nmi_req) |-> wake); // R11
    AST_WAKE_RUN: assert property (@(posedge clk) disable iff (rst)
        !lp_mode |-> !wake); // R11

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    localparam int N   = 8;
    localparam int RTI = 0;

    logic         clk = 1'b0;
    logic         rst, rst_req, nmi_req, imask, cfg_we, special_mode, lp_mode;
    logic [1:0]   rst_kind;
    logic [N-1:0] irq_req, irq_en;
    logic [7:0]   cfg_wdata;
    logic         wake, vec_valid;
    logic [15:0]  vec_addr;

    always #2 clk = ~clk;

    irq_vector_ctrl #(.NUM_SRC(N), .RTI_IDX(RTI), .VEC_BASE(16'hFFFE)) u_irq_vector_ctrl (
        .clk(clk), .rst(rst), .rst_req(rst_req), .rst_kind(rst_kind), .nmi_req(nmi_req),
        .irq_req(irq_req), .irq_en(irq_en), .imask(imask), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .special_mode(special_mode), .lp_mode(lp_mode),
        .wake(wake), .vec_addr(vec_addr), .vec_valid(vec_valid)
    );

    typedef struct {
        int          due;
        logic [16:0] exp;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    int   promo = -1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] src_vec(int i);
        return 16'hFFF6 - 16'(2 * i);
    endfunction

    // expected {valid, addr} from the requirements
    function automatic logic [16:0] model();
        logic [N-1:0] v;
        bit           moved;
        int           src;
        if (rst_req) begin
            case (rst_kind)
                2'd1: return {1'b1, 16'hFFFC};
                2'd2: return {1'b1, 16'hFFFA};
                default: return {1'b1, 16'hFFFE};
            endcase
        end
        if (nmi_req) return {1'b1, 16'hFFF8};
        if (imask) return 17'h0;
        v = irq_req & irq_en;
        if (promo >= 0 && v[promo]) return {1'b1, src_vec(promo)};
        moved = (promo >= 0) && (promo != RTI);
        for (int j = 0; j < N; j++) begin
            src = j;
            if (moved && j == promo) src = RTI;
            else if (moved && j == RTI) src = -1;
            if (src >= 0 && v[src]) return {1'b1, src_vec(src)};
        end
        return 17'h0;
    endfunction

    task automatic step(string tag);
        exp_t e;
        e.due = cyc + 1;
        e.exp = model();
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle();
        rst_req = 0; nmi_req = 0; irq_req = '0; imask = 0; lp_mode = 0; cfg_we = 0;
    endtask

    task automatic write_promo(logic [7:0] b, logic sp, string tag);
        idle();
        cfg_we = 1; cfg_wdata = b; special_mode = sp;
        step(tag);
        cfg_we = 0; special_mode = 0;
        if (sp) begin
            promo = -1;
            for (int i = 0; i < N; i++) if (src_vec(i)[7:0] == b && promo < 0) promo = i;
        end
    endtask

    task automatic req(logic [N-1:0] r, string tag);
        idle(); irq_req = r; step(tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, {15'h0, vec_valid, vec_addr}, {15'h0, e.exp});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1; idle(); rst_kind = 0; irq_en = '1; cfg_wdata = 0; special_mode = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R12 reset outputs", {15'h0, vec_valid, vec_addr}, 32'h0);

        req('0, "R10 idle outputs zero");
        // R10: output does not move before the clock edge
        idle(); irq_req = 8'h28;
        #1 chk("R10 no same-cycle change", {15'h0, vec_valid, vec_addr}, 32'h0);
        step("R3 src3 over src5");
        req(8'h80, "R3 lone src7");
        irq_en = 8'hFE;
        req(8'h09, "R5 disabled src0 skipped");
        irq_en = '1;
        idle(); irq_req = 8'h0F; imask = 1; step("R4 mask silences");
        idle(); irq_req = 8'h01; imask = 1; nmi_req = 1; step("R2 nmi ignores mask");
        for (int k = 0; k < 4; k++) begin
            idle(); rst_req = 1; rst_kind = 2'(k); nmi_req = 1; irq_req = 8'hFF;
            step($sformatf("R1 reset kind %0d", k));
        end
        idle(); rst_kind = 0;

        write_promo(8'hEC, 1'b0, "R8 write cycle");
        req(8'h21, "R8 normal-mode write ignored");
        write_promo(8'hEC, 1'b1, "R6 write cycle");
        req(8'h21, "R6 promoted src5 wins");
        req(8'h09, "R7 src3 beats displaced rti");
        req(8'h41, "R7 displaced rti beats src6");
        req(8'h40, "R7 src6 alone");
        idle(); irq_req = 8'h21; imask = 1; step("R4 promoted still masked");

        // R11 wake checks
        idle(); lp_mode = 1; nmi_req = 1; imask = 1;
        #1 chk("R11 wake on nmi", {31'h0, wake}, 32'h1);
        idle(); lp_mode = 1; irq_req = 8'h04;
        #1 chk("R11 wake on irq", {31'h0, wake}, 32'h1);
        imask = 1;
        #1 chk("R11 masked irq no wake", {31'h0, wake}, 32'h0);
        imask = 0; irq_en = 8'hFB;
        #1 chk("R11 disabled irq no wake", {31'h0, wake}, 32'h0);
        irq_en = '1; lp_mode = 0; nmi_req = 1;
        #1 chk("R11 run mode no wake", {31'h0, wake}, 32'h0);
        step("R2 nmi after wake checks");

        write_promo(8'h55, 1'b1, "R9 write cycle");
        req(8'h21, "R9 unmatched byte default order");

        write_promo(8'hF0, 1'b1, "R6 write src3");
        req(8'h0A, "R6 promoted src3 over src1");
        idle(); rst = 1; @(negedge clk);
        chk("R12 reset mid-run", {15'h0, vec_valid, vec_addr}, 32'h0);
        rst = 0; promo = -1;
        req(8'h0A, "R12 promotion cleared");
        req('0, "R10 back to idle");
        @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule